// File: doc/BRIEF.md
# Multiplexed Keypad Matrix Register

This block is a byte-wide, memory-mapped keypad register for a CPU subsystem. Eight buttons are split into two groups of four. The CPU writes two active-low group-select bits and then reads back the chosen group as an active-low nibble, so a pressed button reads as 0. When both selects are low, the two groups are merged. When neither select is low, the nibble reports a player index instead of buttons. An external multi-controller extension drives that index. While the index is non-zero, the live buttons are treated as released.

The register value is recomputed on every CPU write. It is also recomputed every clock (parameter `CONTINUOUS = 1`) or only on a poll request (`CONTINUOUS = 0`). Whenever a low bit of the register falls from 1 to 0 between two evaluations, the block raises a one-cycle keypad interrupt request. An interrupt controller is expected to latch this request into its keypad flag.

A two-state machine sequences the evaluations. ST_PRIME is entered by reset. It loads the first value without raising an interrupt, then takes the transition PRIME_DONE to ST_TRACK. ST_TRACK re-evaluates on a write, or on a scan (every clock, or on a poll). It stays in ST_TRACK through the transition TRACK_HOLD.

Top module: `keypad_mux_reg`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `rd_data` reads 0xFF as long as the player index is 0. `irq_req` is 0 during reset and on that first clock.
- R2: A write stores `wr_data` with bits 3:0 forced to 1. `rd_data` bits 7:6 always read 1. `rd_data` bits 5:4 echo the stored select bits. The read value is `(0xCF | stored) XOR {4'h0, nibble}`, visible one clock after the write.
- R3: With select bits 5:4 = 2'b10, the nibble is `btn[3:0]` (a 1 in `btn` means pressed).
- R4: With select bits 5:4 = 2'b01, the nibble is `btn[7:4]`.
- R5: With select bits 5:4 = 2'b00, the nibble is `btn[3:0] | btn[7:4]`.
- R6: With select bits 5:4 = 2'b11, the nibble is the player index, zero-extended to 4 bits.
- R7: While `player` is non-zero, `btn` is treated as all zeros for every select value.
- R8: `irq_req` is 1 for one clock after an evaluation in which some bit of `rd_data[3:0]` went from 1 to 0. It is 0 after an evaluation with no such fall.
- R9: A write compares against an all-ones low nibble. `irq_req` follows the write exactly when the new `rd_data[3:0]` is not 4'hF.
- R10: A change of `rd_data[3:0]` bits from 0 to 1 alone (a button release) raises no interrupt.
- R11: With `CONTINUOUS = 0`, `rd_data` holds while neither `wr_en` nor `poll_req` is high, even when `btn` or `player` change. A `poll_req` re-evaluates with the same edge rule as R8.
- R12: With `CONTINUOUS = 1`, a change of `btn` appears on `rd_data` one clock later without any CPU access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the register |
| wr_data | input | 8 | CPU write data; only bits 5:4 matter |
| poll_req | input | 1 | Request to re-evaluate the register |
| btn | input | 8 | Live button vector, 1 = pressed; bits 3:0 first group, 7:4 second group |
| player | input | PID_W | Player index from the multi-controller extension |
| rd_data | output | 8 | Register read value |
| irq_req | output | 1 | One-cycle keypad interrupt request |

## Verification
The hardest situation to reach from the ports is a falling edge that only a select write can reveal. This happens when a button in one group is already held, and the CPU then switches the select onto that group. The write must raise the interrupt even though no button moved. The stimulus holds a second-group button under the first-group select, then writes the second-group select. It also runs a poll-only instance beside the scanning one. Button and player changes between polls must then leave its read value untouched until the poll arrives.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
    localparam int GROUP_W = 4;
    localparam int BTN_W   = 2 * GROUP_W;
    localparam int REG_W   = 8;

    // Decoded view of the two active-low select bits
    typedef enum logic [1:0] {
        SEL_BOTH   = 2'b00,
        SEL_HIGH   = 2'b01,
        SEL_LOW    = 2'b10,
        SEL_PLAYER = 2'b11
    } sel_mode_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_TRACK = 1'b1
    } kp_state_e;

    localparam logic [REG_W-1:0] FIXED_ONES = 8'hCF;
    localparam logic [REG_W-1:0] LOW_FORCE  = 8'h0F;
endpackage

// File: rtl/keypad_group_sel.sv
module keypad_group_sel
    import keypad_pkg::*;
#(
    parameter int PID_W = 2
) (
    input  sel_mode_e             mode,
    input  logic [BTN_W-1:0]      btn,
    input  logic [PID_W-1:0]      player,
    output logic [GROUP_W-1:0]    nibble
);
    logic [BTN_W-1:0]   btn_eff;
    logic [GROUP_W-1:0] pid_nib;

    // Any non-zero player index masks the live buttons
    assign btn_eff = (player != '0) ? '0 : btn;

    generate
        if (PID_W >= GROUP_W) begin : g_pid_trunc
            assign pid_nib = player[GROUP_W-1:0];
        end else begin : g_pid_ext
            assign pid_nib = {{(GROUP_W-PID_W){1'b0}}, player};
        end
    endgenerate

    always_comb begin
        nibble = '0;
        unique case (mode)
            SEL_LOW:    nibble = btn_eff[GROUP_W-1:0];
            SEL_HIGH:   nibble = btn_eff[BTN_W-1:GROUP_W];
            SEL_BOTH:   nibble = btn_eff[GROUP_W-1:0] | btn_eff[BTN_W-1:GROUP_W];
            SEL_PLAYER: nibble = pid_nib;
        endcase
    end
endmodule

// File: rtl/keypad_fall_det.sv
module keypad_fall_det
    import keypad_pkg::*;
(
    input  logic [GROUP_W-1:0] prev_low,
    input  logic [GROUP_W-1:0] next_low,
    output logic               fall
);
    logic [GROUP_W-1:0] drop;

    assign drop = prev_low & ~next_low;
    assign fall = |drop;
endmodule

// File: rtl/keypad_mux_reg.sv
module keypad_mux_reg
    import keypad_pkg::*;
#(
    parameter int PID_W      = 2,
    parameter bit CONTINUOUS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             poll_req,
    input  logic [7:0]       btn,
    input  logic [PID_W-1:0] player,
    output logic [7:0]       rd_data,
    output logic             irq_req
);
    kp_state_e          st_q, st_d;
    logic [REG_W-1:0]   stored_q;
    logic [REG_W-1:0]   value_q;
    logic               irq_q;

    logic [REG_W-1:0]   eval_byte;
    logic [REG_W-1:0]   new_val;
    logic [GROUP_W-1:0] nibble;
    logic [GROUP_W-1:0] prev_low;
    logic               fall;
    logic               scan;
    logic               load;
    logic               irq_d;
    sel_mode_e          mode;

    // A write is evaluated against the byte being written
    assign eval_byte = wr_en ? (wr_data | LOW_FORCE) : stored_q;
    assign mode      = sel_mode_e'(eval_byte[5:4]);

    keypad_group_sel #(.PID_W(PID_W)) u_sel (
        .mode   (mode),
        .btn    (btn),
        .player (player),
        .nibble (nibble)
    );

    assign new_val  = (FIXED_ONES | eval_byte) ^ {{(REG_W-GROUP_W){1'b0}}, nibble};
    // A write compares against an all-ones low nibble
    assign prev_low = wr_en ? {GROUP_W{1'b1}} : value_q[GROUP_W-1:0];

    keypad_fall_det u_fall (
        .prev_low (prev_low),
        .next_low (new_val[GROUP_W-1:0]),
        .fall     (fall)
    );

    generate
        if (CONTINUOUS) begin : g_scan_always
            assign scan = 1'b1;
        end else begin : g_scan_poll
            assign scan = poll_req;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PRIME;
        else        st_q <= st_d;
    end

    // Next state and evaluation outputs
    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        irq_d = 1'b0;
        unique case (st_q)
            ST_PRIME: begin
                load  = 1'b1;
                irq_d = wr_en & fall;
                st_d  = ST_TRACK;
            end
            ST_TRACK: begin
                if (wr_en || scan) begin
                    load  = 1'b1;
                    irq_d = fall;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= 8'hFF;
            value_q  <= 8'hFF;
            irq_q    <= 1'b0;
        end else begin
            if (wr_en) stored_q <= wr_data | LOW_FORCE;
            if (load)  value_q  <= new_val;
            irq_q <= irq_d;
        end
    end

    assign rd_data = value_q;
    assign irq_req = irq_q;
endmodule

// File: rtl/keypad_mux_reg_chk.sv
module keypad_mux_reg_chk #(
    parameter int PID_W      = 2,
    parameter bit CONTINUOUS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             poll_req,
    input logic [7:0]       btn,
    input logic [PID_W-1:0] player,
    input logic [7:0]       rd_data,
    input logic             irq_req
);
    logic primed_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_seen <= 1'b0;
        else        primed_seen <= 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'hFF && !irq_req));

    assert_fixed_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b11);

    assert_low_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5:4] == 2'b10 && player == '0)
        |=> rd_data[3:0] == ~$past(btn[3:0]));

    assert_irq_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !$past(wr_en)) |-> (($past(rd_data[3:0]) & ~rd_data[3:0]) != 4'h0));

    assert_write_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (irq_req == (rd_data[3:0] != 4'hF)));

    generate
        if (!CONTINUOUS) begin : g_poll_only
            assert_hold_no_poll_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (primed_seen && !wr_en && !poll_req) |=> $stable(rd_data));
        end
    endgenerate
endmodule

bind keypad_mux_reg keypad_mux_reg_chk #(.PID_W(PID_W), .CONTINUOUS(CONTINUOUS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .poll_req (poll_req),
    .btn      (btn),
    .player   (player),
    .rd_data  (rd_data),
    .irq_req  (irq_req)
);

// File: tb/keypad_mux_reg_tb.sv
`timescale 1ns/1ps
module keypad_mux_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       poll_req = 1'b0;
    logic [7:0] btn = 8'h00;
    logic [1:0] player = 2'b00;
    logic [7:0] rd_a, rd_b;
    logic       irq_a, irq_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keypad_mux_reg #(.PID_W(2), .CONTINUOUS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .poll_req(poll_req), .btn(btn), .player(player),
        .rd_data(rd_a), .irq_req(irq_a)
    );

    keypad_mux_reg #(.PID_W(2), .CONTINUOUS(1'b0)) u_dut_poll (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .poll_req(poll_req), .btn(btn), .player(player),
        .rd_data(rd_b), .irq_req(irq_b)
    );

    typedef struct {
        logic [7:0] rd [2];
        logic       irq [2];
        string      tag;
    } exp_t;

    exp_t q[$];

    // Reference model state, one per instance (0 = scanning, 1 = poll-only)
    logic [7:0] m_stored [2];
    logic [7:0] m_val [2];
    bit         m_primed [2];

    function automatic logic [3:0] pick(input logic [7:0] sb, input logic [7:0] b,
                                        input logic [1:0] pid);
        logic [7:0] e;
        e = (pid != 2'b00) ? 8'h00 : b;
        case (sb[5:4])
            2'b10:   return e[3:0];
            2'b01:   return e[7:4];
            2'b00:   return e[3:0] | e[7:4];
            default: return {2'b00, pid};
        endcase
    endfunction

    task automatic step(input bit rst, input bit wr, input logic [7:0] wd, input bit pl,
                        input logic [7:0] b, input logic [1:0] pid, input string tag);
        exp_t it;
        logic [7:0] nv;
        @(negedge clk);
        rst_n = !rst; wr_en = wr; wr_data = wd; poll_req = pl; btn = b; player = pid;
        for (int m = 0; m < 2; m++) begin
            it.irq[m] = 1'b0;
            if (rst) begin
                m_stored[m] = 8'hFF; m_val[m] = 8'hFF; m_primed[m] = 1'b0;
            end else if (wr) begin
                m_stored[m] = wd | 8'h0F;
                nv = (8'hCF | m_stored[m]) ^ {4'h0, pick(m_stored[m], b, pid)};
                it.irq[m] = (nv[3:0] != 4'hF);
                m_val[m] = nv; m_primed[m] = 1'b1;
            end else if (!m_primed[m]) begin
                m_val[m] = (8'hCF | m_stored[m]) ^ {4'h0, pick(m_stored[m], b, pid)};
                m_primed[m] = 1'b1;
            end else if (m == 0 || pl) begin
                nv = (8'hCF | m_stored[m]) ^ {4'h0, pick(m_stored[m], b, pid)};
                it.irq[m] = |(m_val[m][3:0] & ~nv[3:0]);
                m_val[m] = nv;
            end
            it.rd[m] = m_val[m];
        end
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                logic [7:0] ard [2];
                logic       airq [2];
                it = q.pop_front();
                ard[0] = rd_a; ard[1] = rd_b; airq[0] = irq_a; airq[1] = irq_b;
                for (int m = 0; m < 2; m++) begin
                    checks++;
                    if (ard[m] !== it.rd[m]) begin
                        failures++;
                        $display("FAIL %s inst%0d rd_data actual=%02h expected=%02h",
                                 it.tag, m, ard[m], it.rd[m]);
                    end
                    checks++;
                    if (airq[m] !== it.irq[m]) begin
                        failures++;
                        $display("FAIL %s inst%0d irq_req actual=%0b expected=%0b",
                                 it.tag, m, airq[m], it.irq[m]);
                    end
                end
            end
        end
    end

    initial begin
        step(1, 0, 8'h00, 0, 8'h00, 2'd0, "R1 reset");
        step(1, 0, 8'h00, 0, 8'h00, 2'd0, "R1 reset hold");
        step(0, 0, 8'h00, 0, 8'h00, 2'd0, "R1 prime");
        step(0, 1, 8'h20, 0, 8'h00, 2'd0, "R2 write low select");
        step(0, 0, 8'h00, 0, 8'h05, 2'd0, "R3 R12 press low group");
        step(0, 0, 8'h00, 1, 8'h05, 2'd0, "R11 poll catches press");
        step(0, 0, 8'h00, 0, 8'h50, 2'd0, "R10 release low press high");
        step(0, 1, 8'h10, 0, 8'h50, 2'd0, "R4 R9 select held high group");
        step(0, 1, 8'hC3, 0, 8'h12, 2'd0, "R5 R2 merge both groups");
        step(0, 1, 8'h30, 0, 8'h12, 2'd0, "R6 player select idx0");
        step(0, 0, 8'h00, 0, 8'h12, 2'd2, "R6 R8 player index two");
        step(0, 0, 8'h00, 0, 8'h12, 2'd2, "R8 steady no irq");
        step(0, 1, 8'h20, 0, 8'hFF, 2'd2, "R7 buttons masked");
        step(0, 0, 8'h00, 0, 8'hFF, 2'd1, "R7 R11 masked other index");
        step(0, 0, 8'h00, 0, 8'hFF, 2'd0, "R8 unmask falls");
        step(0, 0, 8'h00, 1, 8'hFF, 2'd0, "R11 poll unmask");
        step(0, 0, 8'h00, 0, 8'h00, 2'd0, "R10 release all");
        step(1, 0, 8'h00, 0, 8'h00, 2'd0, "R1 mid run reset");
        step(0, 0, 8'h00, 0, 8'h00, 2'd0, "R1 prime again");
        step(0, 1, 8'h20, 0, 8'h08, 2'd0, "R9 write with held key");
        @(negedge clk);
        wr_en = 1'b0; poll_req = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule